// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a processor's store port and a memory write port. It keeps a few pending block-sized writes. Each slot holds a block-aligned address, one data word for every word position in the block, and a mask that marks which bytes are valid. When a store lands in a block that already has a pending slot, the store is folded into that slot. Otherwise it claims a free slot. Either way the processor keeps running while earlier slots drain to memory in the background.

Slots leave in the order they were claimed. Each one goes out as a single block write over a valid/ready handshake, and the byte mask travels with it, so only the bytes that were written reach memory. The slot at the front of the queue is already being offered to memory, so it is closed to further folding. Stores that decode into the I/O window are never folded, and nothing is folded into a slot that holds one. A stall is raised toward the pipeline only when the store cannot fold, every slot is occupied, and no slot is retiring in that same cycle.

Top module: `wbuf_merge`

## Requirements
- R1: After reset, `mem_valid` is 0 and `st_stall` is 0.
- R2: A store to an empty buffer is presented on the memory port in the following cycle. `mem_addr` is the store address with its low 4 bits cleared. The word lands in data bits [32*w+31:32*w], where w = `st_addr[3:2]`. Its byte enables land in `mem_be` bits [4*w+3:4*w], and all other `mem_be` bits are 0.
- R3: A store whose 28-bit block tag (`st_addr[31:4]`) matches a pending slot that is neither the front slot nor an I/O slot is folded into that slot. No new slot is used, and the combined bytes leave in one memory write.
- R4: When a folded store writes a byte that is already valid in the slot, the newer byte value replaces the older one.
- R5: Slots are written to memory oldest first, one transfer per slot. While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_data` and `mem_be` hold steady.
- R6: The front slot (the one shown on the memory port) never takes a folded store. A store to its block claims a new slot.
- R7: A store with `st_addr[31:28] == 4'hF` (the I/O window) always claims its own slot. No later store is folded into that slot.
- R8: `st_stall` is 1 only when a valid store cannot fold, all 4 slots are occupied, and no transfer completes in that cycle. A store that can fold is accepted even when all slots are occupied.
- R9: When all slots are occupied and a transfer completes in the same cycle as a new store, the store takes the freed slot without a stall.
- R10: While fewer than 4 slots are occupied, `st_stall` stays 0, whether or not memory accepts transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 32 | Store word |
| st_be | input | 4 | Byte enables within the word |
| st_stall | output | 1 | Store not accepted this cycle |
| mem_valid | output | 1 | Block write offered to memory |
| mem_ready | input | 1 | Memory accepts the offered write |
| mem_addr | output | 32 | Block-aligned write address |
| mem_data | output | 128 | Block write data |
| mem_be | output | 16 | Per-byte write enables |

## Verification
The folding logic is exercised with several store patterns, each chosen to separate one behaviour from another:
- Stores to different blocks separate slot claiming from folding.
- Repeated stores to the same non-front block show that folding happens and that a newer byte replaces an older one.
- A repeat store to the block of the front slot shows that a slot already on offer is closed to folding.
- I/O-window stores to the same block show that folding is suppressed there, and never applied to a slot holding an I/O store.
- A full buffer is then driven three ways: with an unfoldable store, with a foldable store, and with an unfoldable store in the same cycle as a completing transfer. This separates a real stall from a merge while full and from a slot reused in the cycle it frees.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    parameter int ADDR_W        = 32;
    parameter int WORD_W        = 32;
    parameter int WORDS_PER_BLK = 4;
    parameter int NUM_ENT       = 4;

    localparam int WB        = WORD_W / 8;
    localparam int BLK_W     = WORD_W * WORDS_PER_BLK;
    localparam int BLK_BYTES = BLK_W / 8;
    localparam int OFS_W     = $clog2(BLK_BYTES);
    localparam int BSEL_W    = $clog2(WB);
    localparam int TAG_W     = ADDR_W - OFS_W;
    localparam int IDX_W     = $clog2(NUM_ENT);
    localparam int CNT_W     = IDX_W + 1;

    typedef struct packed {
        logic                 io;
        logic [TAG_W-1:0]     tag;
        logic [BLK_BYTES-1:0] be;
        logic [BLK_W-1:0]     data;
    } wb_entry_t;

    function automatic logic [BLK_W-1:0] byte_mask(input logic [BLK_BYTES-1:0] be);
        logic [BLK_W-1:0] m;
        for (int i = 0; i < BLK_BYTES; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    function automatic wb_entry_t shape_store(input logic [ADDR_W-1:0] addr,
                                              input logic [WORD_W-1:0] data,
                                              input logic [WB-1:0]     be,
                                              input logic              io);
        wb_entry_t e;
        int w;
        w = int'(addr[OFS_W-1:BSEL_W]);
        e.io   = io;
        e.tag  = addr[ADDR_W-1:OFS_W];
        e.be   = '0;
        e.data = '0;
        e.be[w*WB +: WB]           = be;
        e.data[w*WORD_W +: WORD_W] = data;
        e.data = e.data & byte_mask(e.be);
        return e;
    endfunction

    function automatic wb_entry_t fold(input wb_entry_t old, input wb_entry_t upd);
        wb_entry_t r;
        logic [BLK_W-1:0] m;
        m      = byte_mask(upd.be);
        r      = old;
        r.data = (old.data & ~m) | (upd.data & m);
        r.be   = old.be | upd.be;
        return r;
    endfunction
endpackage

// File: rtl/wbuf_match.sv
module wbuf_match
    import wbuf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_ENT-1:0][TAG_W-1:0] tags,
    input  logic [NUM_ENT-1:0]          slot_io,
    input  logic [NUM_ENT-1:0]          vld,
    input  logic [NUM_ENT-1:0]          locked,
    input  logic [TAG_W-1:0]            tag,
    input  logic                        bypass,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [NUM_ENT-1:0] cand;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
        assign cand[i] = vld[i] & ~locked[i] & ~slot_io[i] & ~bypass & (tags[i] == tag);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // R3: at most one open slot per block
    assert_single_match_R3: assert property (@(posedge clk) disable iff (rst) $onehot0(cand));
endmodule

// File: rtl/wbuf_order.sv
module wbuf_order
    import wbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             drain,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    logic [CNT_W-1:0] cnt;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (int'(p) == NUM_ENT - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (alloc) tail <= step(tail);
            if (drain) head <= step(head);
            cnt <= cnt + CNT_W'(alloc) - CNT_W'(drain);
        end
    end

    assign full  = (int'(cnt) == NUM_ENT);
    assign empty = (cnt == '0);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst) (alloc && full) |-> drain);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst) drain |-> !empty);
endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
    import wbuf_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] IO_MASK = 32'hF000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_valid,
    input  logic [ADDR_W-1:0]    st_addr,
    input  logic [WORD_W-1:0]    st_data,
    input  logic [WB-1:0]        st_be,
    output logic                 st_stall,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BLK_W-1:0]     mem_data,
    output logic [BLK_BYTES-1:0] mem_be
);
    wb_entry_t                     ent [NUM_ENT];
    logic [NUM_ENT-1:0]            vld;
    logic [NUM_ENT-1:0]            locked;
    logic [NUM_ENT-1:0][TAG_W-1:0] tags;
    logic [NUM_ENT-1:0]            slot_io;
    logic [IDX_W-1:0]              head, tail, hit_idx;
    logic                          full, empty, hit, st_io, drain, do_alloc, do_merge;
    wb_entry_t                     inc;

    assign st_io = ((st_addr & IO_MASK) == IO_BASE);
    assign inc   = shape_store(st_addr, st_data, st_be, st_io);

    always_comb begin
        locked = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            tags[i]    = ent[i].tag;
            slot_io[i] = ent[i].io;
        end
        if (mem_valid) locked[head] = 1'b1;
    end

    wbuf_match u_match (
        .clk(clk), .rst(rst), .tags(tags), .slot_io(slot_io), .vld(vld),
        .locked(locked), .tag(inc.tag), .bypass(st_io), .hit(hit), .hit_idx(hit_idx)
    );

    wbuf_order u_order (
        .clk(clk), .rst(rst), .alloc(do_alloc), .drain(drain),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    assign mem_valid = !empty;
    assign mem_addr  = {ent[head].tag, {OFS_W{1'b0}}};
    assign mem_data  = ent[head].data;
    assign mem_be    = ent[head].be;
    assign drain     = mem_valid && mem_ready;

    assign do_merge  = st_valid && hit;
    assign do_alloc  = st_valid && !hit && (!full || drain);
    assign st_stall  = st_valid && !hit && full && !drain;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            for (int i = 0; i < NUM_ENT; i++) ent[i] <= '0;
        end else begin
            if (drain) vld[head] <= 1'b0;
            if (do_alloc) begin
                vld[tail] <= 1'b1;
                ent[tail] <= inc;
            end
            if (do_merge) ent[hit_idx] <= fold(ent[hit_idx], inc);
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));
    assert_io_nomerge_R7: assert property (@(posedge clk) disable iff (rst) do_merge |-> !st_io);
    assert_front_closed_R6: assert property (@(posedge clk) disable iff (rst)
        (do_merge && mem_valid) |-> (hit_idx != head));
    assert_stall_keeps_R8: assert property (@(posedge clk) disable iff (rst) st_stall |=> (vld == $past(vld)));
endmodule

// File: tb/sim_wbuf_merge.sv
module sim_wbuf_merge;
    logic clk = 0, rst = 1;
    logic st_valid = 0, mem_ready = 0;
    logic [31:0] st_addr = 0, st_data = 0;
    logic [3:0] st_be = 0;
    logic st_stall, mem_valid;
    logic [31:0] mem_addr;
    logic [127:0] mem_data;
    logic [15:0] mem_be;

    always #4 clk = ~clk;

    wbuf_merge u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_be(st_be), .st_stall(st_stall), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
    );

    int checks = 0, fails = 0, nrec = 0;
    bit done = 0;
    logic s_stall, s_mv;
    logic [31:0] s_ma;
    logic [127:0] s_md;
    logic [15:0] s_mb;
    logic [31:0] rec_addr [16];
    logic [127:0] rec_data [16];
    logic [15:0] rec_be [16];

    function automatic logic [127:0] m128(input logic [15:0] be);
        logic [127:0] m;
        for (int i = 0; i < 16; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] b, input logic r);
        @(negedge clk);
        st_valid = v; st_addr = a; st_data = d; st_be = b; mem_ready = r;
        #2;
        s_stall = st_stall; s_mv = mem_valid; s_ma = mem_addr; s_md = mem_data; s_mb = mem_be;
        if (s_mv && r && nrec < 16) begin
            rec_addr[nrec] = s_ma; rec_data[nrec] = s_md & m128(s_mb); rec_be[nrec] = s_mb;
            nrec++;
        end
        @(posedge clk);
        #1 st_valid = 0;
    endtask

    task automatic drain_all();
        for (int i = 0; i < 12; i++) cycle(0, 0, 0, 0, 1);
        check(s_mv == 0, "R5 empty after drain", 128'(s_mv), 0);
    endtask

    task automatic t_reset();
        cycle(0, 0, 0, 0, 0);
        check(s_mv == 0, "R1 mem_valid", 128'(s_mv), 0);
        check(s_stall == 0, "R1 st_stall", 128'(s_stall), 0);
    endtask

    task automatic t_single();
        nrec = 0;
        cycle(1, 32'h108, 32'hAABBCCDD, 4'hF, 0);
        cycle(0, 0, 0, 0, 0);
        check(s_mv == 1, "R2 valid", 128'(s_mv), 1);
        check(s_ma == 32'h100, "R2 addr", 128'(s_ma), 128'h100);
        check(s_mb == 16'h0F00, "R2 be", 128'(s_mb), 128'h0F00);
        check(s_md[95:64] == 32'hAABBCCDD, "R2 data", 128'(s_md[95:64]), 128'hAABBCCDD);
        cycle(0, 0, 0, 0, 0);
        check(s_ma == 32'h100 && s_mb == 16'h0F00, "R5 hold", 128'(s_ma), 128'h100);
        drain_all();
        check(nrec == 1, "R5 one transfer", 128'(nrec), 1);
    endtask

    task automatic t_fold();
        nrec = 0;
        cycle(1, 32'h200, 32'h01020304, 4'hF, 0);
        cycle(1, 32'h304, 32'h11112222, 4'h3, 0);
        cycle(1, 32'h30C, 32'h33334444, 4'hC, 0);
        cycle(1, 32'h304, 32'h00000099, 4'h1, 0);
        drain_all();
        check(nrec == 2, "R3 folded count", 128'(nrec), 2);
        check(rec_addr[0] == 32'h200, "R5 order first", 128'(rec_addr[0]), 128'h200);
        check(rec_addr[1] == 32'h300, "R3 addr", 128'(rec_addr[1]), 128'h300);
        check(rec_be[1] == 16'hC030, "R3 be", 128'(rec_be[1]), 128'hC030);
        check(rec_data[1] == 128'h33330000_00000000_00002299_00000000, "R4 data", rec_data[1],
              128'h33330000_00000000_00002299_00000000);
    endtask

    task automatic t_front();
        nrec = 0;
        cycle(1, 32'h400, 32'hA0A0A0A0, 4'hF, 0);
        cycle(1, 32'h404, 32'hB0B0B0B0, 4'hF, 0);
        drain_all();
        check(nrec == 2, "R6 count", 128'(nrec), 2);
        check(rec_be[0] == 16'h000F && rec_be[1] == 16'h00F0, "R6 split", 128'(rec_be[1]), 128'h00F0);
    endtask

    task automatic t_io();
        nrec = 0;
        cycle(1, 32'h500, 32'h5, 4'hF, 0);
        cycle(1, 32'hF0000010, 32'hCAFE0001, 4'hF, 0);
        cycle(1, 32'hF0000014, 32'hCAFE0002, 4'hF, 0);
        drain_all();
        check(nrec == 3, "R7 count", 128'(nrec), 3);
        check(rec_addr[1] == 32'hF0000010 && rec_be[1] == 16'h000F, "R7 first", 128'(rec_be[1]), 128'h000F);
        check(rec_addr[2] == 32'hF0000010 && rec_be[2] == 16'h00F0, "R7 second", 128'(rec_be[2]), 128'h00F0);
    endtask

    task automatic t_full();
        nrec = 0;
        for (int i = 0; i < 4; i++) begin
            cycle(1, 32'h600 + 32'(i * 16), 32'(i), 4'hF, 0);
            check(s_stall == 0, "R10 no stall", 128'(s_stall), 0);
        end
        cycle(1, 32'h640, 32'h40, 4'hF, 0);
        check(s_stall == 1, "R8 stall", 128'(s_stall), 1);
        cycle(1, 32'h628, 32'h77, 4'hF, 0);
        check(s_stall == 0, "R8 fold while full", 128'(s_stall), 0);
        cycle(1, 32'h640, 32'h40, 4'hF, 1);
        check(s_stall == 0, "R9 same-cycle reuse", 128'(s_stall), 0);
        drain_all();
        check(nrec == 5, "R9 count", 128'(nrec), 5);
        for (int i = 0; i < 5; i++)
            check(rec_addr[i] == 32'h600 + 32'(i * 16), "R5 order", 128'(rec_addr[i]), 128'(32'h600 + i * 16));
        check(rec_be[2] == 16'h0F0F, "R3 full fold be", 128'(rec_be[2]), 128'h0F0F);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_single();
        t_fold();
        t_front();
        t_io();
        t_full();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule